// File: doc/BRIEF.md
# Dual-Mode Signed/Unsigned Multiplier Tile

This tile multiplies two operand buses either as one full-width product or as two packed half-width products, chosen by a mode input. With the default parameters the operands are 18 bits wide. In wide mode the result is a single 36-bit product. In split mode the tile treats each operand as two 9-bit halves. The lower halves multiply into the low 18-bit field of the result, and the upper halves multiply into the high field.

Each operand has its own signedness input. The same bit patterns can therefore be read as two's complement or as plain binary, and the two operands need not agree. The tile has an input register stage and an output register stage, and a parameter turns each one on or off. The tile can therefore run as pure combinational logic, or with one or two cycles of latency. A clock enable freezes every register that is present. A synchronous clear zeroes those registers.

Top module: `mul_tile`

## Requirements
- R1: With `split_mode` = 0, `product` is the full 36-bit product of `op_a` and `op_b`, taken modulo 2^36 and interpreted according to the two sign inputs.
- R2: With `split_mode` = 1, `product[17:0]` is the 18-bit product of `op_a[8:0]` and `op_b[8:0]`, and `product[35:18]` is the 18-bit product of `op_a[17:9]` and `op_b[17:9]`. Neither half's result depends on the other half's operands.
- R3: `a_signed` = 1 makes operand A two's complement, and 0 makes it unsigned. `b_signed` does the same for operand B. In a mixed pair, only the signed operand is sign-extended. In split mode each sign input applies to both halves of its operand.
- R4: All-ones operands give the largest product when both are unsigned. In wide mode that is 0x3FFFF squared. When both are signed, the same all-ones operands give +1.
- R5: The latency from inputs to `product` is `IN_REG` + `OUT_REG` clock edges while `ce` is high. The default is 2.
- R6: With both register stages disabled, `product` follows the inputs in the same cycle, with no dependence on `clk`, `ce` or `clr`.
- R7: While `ce` is low and `clr` is low, every present register holds its value, so `product` does not change whatever the inputs do.
- R8: `clr` high at a clock edge zeroes every present register, whatever the state of `ce`. `product` reads 0 after that edge and stays 0 until `ce` loads new operands.
- R9: `split_mode` and the sign inputs are captured together with the operands. A product is always formed with the mode and signedness that were present when its operands were sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both register stages |
| clr | input | 1 | Synchronous clear, active high |
| ce | input | 1 | Clock enable for all register stages |
| op_a | input | 18 | Operand A (2*HALF_W bits) |
| op_b | input | 18 | Operand B (2*HALF_W bits) |
| a_signed | input | 1 | 1: operand A is two's complement |
| b_signed | input | 1 | 1: operand B is two's complement |
| split_mode | input | 1 | 0: one wide product, 1: two packed half products |
| product | output | 36 | Wide product, or two 18-bit fields in split mode |

## Verification
On every cycle, the bound checker compares `product` with the product of the operands, mode and signedness that were sampled `IN_REG` + `OUT_REG` edges earlier, whenever `ce` was high across that window. It also checks that the sign bit of a wide signed product is correct, that `product` stays stable while `ce` is low, and that `product` reads zero after a clear. The bench scenarios cover the behaviour that has to be set up deliberately:
- the exact edge on which a new product first appears after a clear;
- the all-ones and most-negative corner operands;
- mixed signedness in each split half;
- the combinational variant tracking its inputs while `ce` is low.

// File: rtl/mul_tile_pkg.sv
package mul_tile_pkg;

    // Default half-operand width; a full operand is twice this.
    localparam int DEF_HALF_W = 9;

    // Number of narrow lanes packed into one tile in split mode.
    localparam int NARROW_LANES = 2;

    typedef enum logic {
        MODE_WIDE  = 1'b0,
        MODE_SPLIT = 1'b1
    } mul_mode_e;

    // Control bits that travel alongside the operands.
    typedef struct packed {
        logic      a_sgn;
        logic      b_sgn;
        mul_mode_e mode;
    } mul_ctrl_t;

    localparam mul_ctrl_t CTRL_IDLE = '{a_sgn: 1'b0, b_sgn: 1'b0, mode: MODE_WIDE};

    function automatic mul_ctrl_t pack_ctrl(logic a_sgn, logic b_sgn, logic split);
        mul_ctrl_t c;
        c.a_sgn = a_sgn;
        c.b_sgn = b_sgn;
        c.mode  = split ? MODE_SPLIT : MODE_WIDE;
        return c;
    endfunction

endpackage

// File: rtl/mul_in_stage.sv
module mul_in_stage
    import mul_tile_pkg::*;
#(
    parameter int W       = 18,
    parameter bit USE_REG = 1'b1
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ce,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  mul_ctrl_t    ctrl_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output mul_ctrl_t    ctrl_o
);

    generate
        if (USE_REG) begin : g_reg
            logic [W-1:0] a_q;
            logic [W-1:0] b_q;
            mul_ctrl_t    ctrl_q;

            always_ff @(posedge clk) begin
                if (clr) begin
                    a_q    <= '0;
                    b_q    <= '0;
                    ctrl_q <= CTRL_IDLE;
                end else if (ce) begin
                    a_q    <= a_i;
                    b_q    <= b_i;
                    ctrl_q <= ctrl_i;
                end
            end

            assign a_o    = a_q;
            assign b_o    = b_q;
            assign ctrl_o = ctrl_q;
        end else begin : g_bypass
            logic unused_bypass;
            assign unused_bypass = &{1'b0, clk, clr, ce};
            assign a_o    = a_i;
            assign b_o    = b_i;
            assign ctrl_o = ctrl_i;
        end
    endgenerate

endmodule

// File: rtl/mul_lane.sv
module mul_lane #(
    parameter int W = 18
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           a_sgn,
    input  logic           b_sgn,
    output logic [2*W-1:0] prod
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    // Only an operand marked signed replicates its top bit.
    assign a_ext = {{W{a_sgn & a[W-1]}}, a};
    assign b_ext = {{W{b_sgn & b[W-1]}}, b};

    // Product modulo 2^PW is exact for every signedness mix.
    assign prod = a_ext * b_ext;

endmodule

// File: rtl/mul_core.sv
module mul_core
    import mul_tile_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W
) (
    input  logic [2*HALF_W-1:0] a,
    input  logic [2*HALF_W-1:0] b,
    input  mul_ctrl_t           ctrl,
    output logic [4*HALF_W-1:0] prod
);

    localparam int W  = 2 * HALF_W;
    localparam int PW = 2 * W;
    localparam int NW = 2 * HALF_W;

    logic [PW-1:0]              wide_prod;
    logic [NARROW_LANES*NW-1:0] narrow_prod;

    mul_lane #(.W(W)) u_wide (
        .a     (a),
        .b     (b),
        .a_sgn (ctrl.a_sgn),
        .b_sgn (ctrl.b_sgn),
        .prod  (wide_prod)
    );

    generate
        for (genvar i = 0; i < NARROW_LANES; i++) begin : g_narrow
            mul_lane #(.W(HALF_W)) u_lane (
                .a     (a[i*HALF_W +: HALF_W]),
                .b     (b[i*HALF_W +: HALF_W]),
                .a_sgn (ctrl.a_sgn),
                .b_sgn (ctrl.b_sgn),
                .prod  (narrow_prod[i*NW +: NW])
            );
        end
    endgenerate

    always_comb begin
        if (ctrl.mode == MODE_SPLIT) begin
            prod = narrow_prod;
        end else begin
            prod = wide_prod;
        end
    end

endmodule

// File: rtl/mul_out_stage.sv
module mul_out_stage #(
    parameter int PW      = 36,
    parameter bit USE_REG = 1'b1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ce,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);

    generate
        if (USE_REG) begin : g_reg
            logic [PW-1:0] q_r;

            always_ff @(posedge clk) begin
                if (clr) begin
                    q_r <= '0;
                end else if (ce) begin
                    q_r <= d;
                end
            end

            assign q = q_r;
        end else begin : g_bypass
            logic unused_bypass;
            assign unused_bypass = &{1'b0, clk, clr, ce};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mul_tile.sv
module mul_tile
    import mul_tile_pkg::*;
#(
    parameter int HALF_W  = DEF_HALF_W,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                ce,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic                a_signed,
    input  logic                b_signed,
    input  logic                split_mode,
    output logic [4*HALF_W-1:0] product
);

    localparam int W  = 2 * HALF_W;
    localparam int PW = 2 * W;

    mul_ctrl_t    ctrl_in;
    mul_ctrl_t    ctrl_s;
    logic [W-1:0] a_s;
    logic [W-1:0] b_s;
    logic [PW-1:0] core_prod;

    assign ctrl_in = pack_ctrl(a_signed, b_signed, split_mode);

    mul_in_stage #(.W(W), .USE_REG(IN_REG)) u_in (
        .clk    (clk),
        .clr    (clr),
        .ce     (ce),
        .a_i    (op_a),
        .b_i    (op_b),
        .ctrl_i (ctrl_in),
        .a_o    (a_s),
        .b_o    (b_s),
        .ctrl_o (ctrl_s)
    );

    mul_core #(.HALF_W(HALF_W)) u_core (
        .a    (a_s),
        .b    (b_s),
        .ctrl (ctrl_s),
        .prod (core_prod)
    );

    mul_out_stage #(.PW(PW), .USE_REG(OUT_REG)) u_out (
        .clk (clk),
        .clr (clr),
        .ce  (ce),
        .d   (core_prod),
        .q   (product)
    );

endmodule

// File: rtl/mul_tile_chk.sv
module mul_tile_chk #(
    parameter int HALF_W  = 9,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                clr,
    input logic                ce,
    input logic [2*HALF_W-1:0] op_a,
    input logic [2*HALF_W-1:0] op_b,
    input logic                a_signed,
    input logic                b_signed,
    input logic                split_mode,
    input logic [4*HALF_W-1:0] product
);

    localparam int W   = 2 * HALF_W;
    localparam int PW  = 2 * W;
    localparam int LAT = int'(IN_REG) + int'(OUT_REG);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         sa;
        logic         sb;
        logic         sp;
    } smp_t;

    smp_t now_s, d1, d2, al;
    logic c1, c2, al_ok;

    assign now_s = '{a: op_a, b: op_b, sa: a_signed, sb: b_signed, sp: split_mode};

    always_ff @(posedge clk) begin
        d1 <= now_s;
        d2 <= d1;
        if (clr) begin
            c1 <= 1'b0;
            c2 <= 1'b0;
        end else begin
            c1 <= ce;
            c2 <= c1;
        end
    end

    always_comb begin
        case (LAT)
            0:       begin al = now_s; al_ok = 1'b1;    end
            1:       begin al = d1;    al_ok = c1;      end
            default: begin al = d2;    al_ok = c1 & c2; end
        endcase
    end

    function automatic logic [PW-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b,
                                               logic sa, logic sb, logic sp);
        logic [PW-1:0]     r;
        logic [HALF_W-1:0] ah, bh;
        longint            va, vb, p;
        r = '0;
        if (!sp) begin
            va = longint'(a);
            vb = longint'(b);
            if (sa && a[W-1]) va = va - (longint'(1) <<< W);
            if (sb && b[W-1]) vb = vb - (longint'(1) <<< W);
            p = va * vb;
            r = p[PW-1:0];
        end else begin
            for (int i = 0; i < 2; i++) begin
                ah = a[i*HALF_W +: HALF_W];
                bh = b[i*HALF_W +: HALF_W];
                va = longint'(ah);
                vb = longint'(bh);
                if (sa && ah[HALF_W-1]) va = va - (longint'(1) <<< HALF_W);
                if (sb && bh[HALF_W-1]) vb = vb - (longint'(1) <<< HALF_W);
                p = va * vb;
                r[i*W +: W] = p[W-1:0];
            end
        end
        return r;
    endfunction

    // R1
    ref_match_chk: assert property (@(posedge clk) disable iff (clr)
        al_ok |-> product == ref_prod(al.a, al.b, al.sa, al.sb, al.sp));

    // R3
    sign_chk: assert property (@(posedge clk) disable iff (clr)
        (al_ok && !al.sp && al.sa && al.sb && (al.a != '0) && (al.b != '0))
        |-> product[PW-1] == (al.a[W-1] ^ al.b[W-1]));

    generate
        if (LAT > 0) begin : g_seq
            // R7
            hold_chk: assert property (@(posedge clk) disable iff (clr)
                !ce |=> $stable(product));

            // R8
            clr_zero_chk: assert property (@(posedge clk)
                clr |=> product == '0);
        end
    endgenerate

endmodule

bind mul_tile mul_tile_chk #(
    .HALF_W  (HALF_W),
    .IN_REG  (IN_REG),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk        (clk),
    .clr        (clr),
    .ce         (ce),
    .op_a       (op_a),
    .op_b       (op_b),
    .a_signed   (a_signed),
    .b_signed   (b_signed),
    .split_mode (split_mode),
    .product    (product)
);

// File: tb/mul_tile_test.sv
module mul_tile_test;

    logic        clk = 1'b0;
    logic        clr, ce;
    logic [17:0] op_a, op_b;
    logic        a_signed, b_signed, split_mode;
    logic [35:0] product, product_c;

    always #5 clk = ~clk;

    mul_tile uut (
        .clk(clk), .clr(clr), .ce(ce), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed), .split_mode(split_mode),
        .product(product)
    );

    mul_tile #(.IN_REG(1'b0), .OUT_REG(1'b0)) uut_comb (
        .clk(clk), .clr(clr), .ce(ce), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed), .split_mode(split_mode),
        .product(product_c)
    );

    int          checks = 0;
    int          errors = 0;
    logic [35:0] q[$];
    string       rq[$];

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic model: operands as integers, wrap the product to the field.
    function automatic logic [35:0] model(logic [17:0] a, logic [17:0] b,
                                          logic sa, logic sb, logic sp);
        logic [35:0] r;
        longint va, vb, p;
        r = '0;
        if (!sp) begin
            va = longint'(a);
            vb = longint'(b);
            if (sa && va >= 131072) va -= 262144;
            if (sb && vb >= 131072) vb -= 262144;
            p = va * vb;
            r = p[35:0];
        end else begin
            for (int h = 0; h < 2; h++) begin
                va = longint'((a >> (9 * h)) & 18'h1FF);
                vb = longint'((b >> (9 * h)) & 18'h1FF);
                if (sa && va >= 256) va -= 512;
                if (sb && vb >= 256) vb -= 512;
                p = va * vb;
                r[18*h +: 18] = p[17:0];
            end
        end
        return r;
    endfunction

    task automatic put(logic [17:0] a, logic [17:0] b, logic sa, logic sb, logic sp);
        op_a = a; op_b = b; a_signed = sa; b_signed = sb; split_mode = sp;
    endtask

    // Called at a falling edge; checks the entry due now, then drives a new one.
    task automatic stream(logic [17:0] a, logic [17:0] b, logic sa, logic sb,
                          logic sp, string req);
        logic [35:0] e;
        if (q.size() == 2) chk(rq.pop_front(), product, q.pop_front());
        put(a, b, sa, sb, sp);
        e = model(a, b, sa, sb, sp);
        q.push_back(e);
        rq.push_back(req);
        #1 chk({req, " R6 comb"}, product_c, e);
        @(negedge clk);
    endtask

    task automatic flush();
        while (q.size() > 0) begin
            chk(rq.pop_front(), product, q.pop_front());
            if (q.size() > 0) @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [35:0] p0;
        logic [17:0] ha, hb;
        clr = 1'b1; ce = 1'b0;
        put(18'h0, 18'h0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 reset state", product, 36'h0);
        clr = 1'b0; ce = 1'b1;

        // R4 all ones under both signedness choices, wide and split
        stream(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 1'b0, "R4 wide unsigned all ones");
        stream(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b1, 1'b0, "R4 wide signed all ones");
        stream(18'h20000, 18'h20000, 1'b1, 1'b1, 1'b0, "R1 most negative squared");
        stream(18'h3FFFF, 18'h00003, 1'b1, 1'b0, 1'b0, "R3 signed A unsigned B");
        stream(18'h00003, 18'h3FFFF, 1'b1, 1'b0, 1'b0, "R3 unsigned B all ones");
        stream(18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 1'b1, "R2 split unsigned all ones");
        stream(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b1, 1'b1, "R2 split signed all ones");
        stream({9'd5, 9'h1FF}, {9'd7, 9'd2}, 1'b1, 1'b0, 1'b1, "R2 R3 split mixed halves");
        stream({9'h100, 9'd0}, {9'h100, 9'h1AB}, 1'b1, 1'b1, 1'b1, "R2 split half isolation");
        for (int i = 0; i < 60; i++) begin
            stream(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom), "R9 random mode and sign");
        end
        flush();

        // R7 hold with ce low
        ce = 1'b0;
        p0 = product;
        ha = 18'h2D3C1; hb = 18'h1F00F;
        put(ha, hb, 1'b1, 1'b0, 1'b0);
        #1 chk("R6 comb ignores ce", product_c, model(ha, hb, 1'b1, 1'b0, 1'b0));
        repeat (3) begin
            @(negedge clk);
            put(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            chk("R7 hold while ce low", product, p0);
        end
        put(ha, hb, 1'b1, 1'b0, 1'b0);
        ce = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 resume after hold", product, model(ha, hb, 1'b1, 1'b0, 1'b0));

        // R8 clear, then stays clear with ce low
        clr = 1'b1;
        put(18'h12345, 18'h0ABCD, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 clear zeroes product", product, 36'h0);
        clr = 1'b0; ce = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R8 stays clear with ce low", product, 36'h0);
        end

        // R5 exact two-edge latency from a cleared pipe
        ce = 1'b1;
        put(18'h0F0F0, 18'h30003, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R5 not visible after one edge", product, 36'h0);
        @(negedge clk);
        chk("R5 visible after two edges", product, model(18'h0F0F0, 18'h30003, 1'b1, 1'b1, 1'b1));

        summary();
        $finish;
    end

endmodule